// File: doc/BRIEF.md
# CDR Holdover and Calibration Controller

This block supervises the digital oscillator control word of a DSP-based phase-locked loop inside a clock-and-data-recovery core. It also gates the recovered outputs. A reset/calibrate pin is qualified by a minimum width counted in system clocks. A long enough high level puts the controller in RESET. When the pin then falls, a calibration request is issued. After the external calibration engine reports done, the controller moves to acquisition.

In ACQUIRE and TRACK, the oscillator word follows the loop filter on its valid strobes. When a reference clock is present during acquisition, the word follows the reference-centring word instead. An active-low lock-to-reference input moves the loop into HOLD. In HOLD the loop filter is ignored. With a reference present, the word tracks the reference word. Without a reference, the word freezes at its last value, which gives holdover.

The rate select sets a divider shift for the oscillator output. The data output can be squelched to zero and the clock output can be disabled.

Top module: `cdr_hold_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is RESET (0), dco_word_o is DCO_INIT (MSB set, all other bits zero), and div_shift_o, data_o, clk_en_o and cal_start_o are all 0.
- R2: If rcal_i is high for MIN_PULSE consecutive clock edges, state_o becomes RESET after the MIN_PULSE-th edge, and dco_word_o returns to DCO_INIT one edge later. A high pulse shorter than MIN_PULSE edges leaves state_o and dco_word_o unchanged.
- R3: In RESET, the first edge with rcal_i low moves state_o to CALIBRATE (1) and raises cal_start_o for exactly one cycle. CALIBRATE moves to ACQUIRE (2) on the edge where cal_done_i is high. While in CALIBRATE, dco_word_o does not change.
- R4: rate_sel_i is sampled only on the edge that enters CALIBRATE. The divider shift is 00→0, 01→1, 10→2, 11→4. Changes to rate_sel_i at any other time leave div_shift_o unchanged.
- R5: In TRACK, and in ACQUIRE with ref_present_i low, dco_word_o loads lf_word_i one edge after an edge where lf_valid_i is high. Without the strobe, dco_word_o holds its value.
- R6: ACQUIRE moves to TRACK (3) on an edge where lock_i is high. TRACK moves back to ACQUIRE on an edge where lock_i is low.
- R7: ltr_ni low moves ACQUIRE or TRACK to HOLD (4) on the next edge. ltr_ni high moves HOLD to ACQUIRE. In RESET and CALIBRATE, ltr_ni has no effect.
- R8: In HOLD with ref_present_i low, dco_word_o is frozen, and lf_valid_i and lf_word_i have no effect on it.
- R9: In HOLD or ACQUIRE with ref_present_i high, dco_word_o takes ref_word_i on every edge.
- R10: data_o is data_i delayed by one edge. On an edge where squelch_i is high, data_o is forced to 0 instead.
- R11: clk_en_o is the inverse of clk_dis_i, delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rcal_i | input | 1 | Reset/calibrate pin, active high, synchronous to clk_i |
| ltr_ni | input | 1 | Lock-to-reference request, active low |
| ref_present_i | input | 1 | Reference clock detected |
| rate_sel_i | input | 2 | Data rate select |
| squelch_i | input | 1 | Force recovered data to zero |
| clk_dis_i | input | 1 | Disable recovered clock output |
| data_i | input | 1 | Recovered data bit |
| lf_word_i | input | DCO_W | Loop-filter frequency word |
| lf_valid_i | input | 1 | Loop-filter word valid strobe |
| ref_word_i | input | DCO_W | Reference-centring frequency word |
| lock_i | input | 1 | Frequency lock indication |
| cal_done_i | input | 1 | Calibration engine finished |
| dco_word_o | output | DCO_W | Registered oscillator control word |
| div_shift_o | output | 3 | Oscillator divide shift (log2 of the divide factor) |
| data_o | output | 1 | Gated recovered data |
| clk_en_o | output | 1 | Recovered clock enable |
| cal_start_o | output | 1 | One-cycle calibration start pulse |
| state_o | output | 3 | Controller state (0 RESET, 1 CALIBRATE, 2 ACQUIRE, 3 TRACK, 4 HOLD) |

## Verification
A wrong state register shows up on the ports in two ways:
- state_o reports the wrong state on the edge after the transition.
- dco_word_o changes, or fails to change, one edge after a loop-filter strobe or reference word that the state should have accepted or ignored.

A fault in the pulse-width filter shows within MIN_PULSE+1 edges. Either a short pulse pulls state_o to RESET, or a long one fails to do so. A rate latched at the wrong moment appears on div_shift_o as soon as rate_sel_i moves during acquisition. The gating paths are visible on data_o and clk_en_o one edge after their controls change.

// File: rtl/cdr_hold_pkg.sv
package cdr_hold_pkg;
  localparam int unsigned DIV_W = 3;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_CAL   = 3'd1,
    ST_ACQ   = 3'd2,
    ST_TRACK = 3'd3,
    ST_HOLD  = 3'd4
  } cdr_state_e;

  function automatic logic [DIV_W-1:0] rate_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   rate_shift = 3'd0;
      2'b01:   rate_shift = 3'd1;
      2'b10:   rate_shift = 3'd2;
      default: rate_shift = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cdr_rst_filter.sv
module cdr_rst_filter #(
  parameter int unsigned MIN_PULSE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rcal_i,
  output logic long_hi_o
);
  localparam int unsigned CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(MIN_PULSE - 1);

  logic [CNT_W-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hi_cnt_q <= '0;
    else if (!rcal_i)          hi_cnt_q <= '0;
    else if (hi_cnt_q != CNT_MAX) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // qualified once the current cycle is the MIN_PULSE-th high cycle
  assign long_hi_o = rcal_i && (hi_cnt_q >= CNT_THR);

  p_pulse_qual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_hi_o |-> $past(rcal_i));
endmodule

// File: rtl/cdr_hold_fsm.sv
module cdr_hold_fsm
  import cdr_hold_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       long_hi_i,
  input  logic       rcal_i,
  input  logic       cal_done_i,
  input  logic       lock_i,
  input  logic       ltr_ni,
  output cdr_state_e state_o,
  output logic       cal_entry_o,
  output logic       cal_start_o
);
  cdr_state_e state_q, state_d;
  logic       cal_start_q;

  always_comb begin
    state_d = state_q;
    if (long_hi_i) begin
      state_d = ST_RESET;
    end else begin
      case (state_q)
        ST_RESET: if (!rcal_i)    state_d = ST_CAL;
        ST_CAL:   if (cal_done_i) state_d = ST_ACQ;
        ST_ACQ: begin
          if (!ltr_ni)     state_d = ST_HOLD;
          else if (lock_i) state_d = ST_TRACK;
        end
        ST_TRACK: begin
          if (!ltr_ni)      state_d = ST_HOLD;
          else if (!lock_i) state_d = ST_ACQ;
        end
        ST_HOLD:  if (ltr_ni) state_d = ST_ACQ;
        default:  state_d = ST_RESET;
      endcase
    end
  end

  assign cal_entry_o = (state_q == ST_RESET) && (state_d == ST_CAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RESET;
      cal_start_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cal_start_q <= cal_entry_o;
    end
  end

  assign state_o     = state_q;
  assign cal_start_o = cal_start_q;

  p_cal_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_q |-> (state_q == ST_CAL));
  p_cal_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_q |=> !cal_start_q);
  p_no_hold_early_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAL) |=> (state_q != ST_HOLD));
endmodule

// File: rtl/cdr_dco_reg.sv
module cdr_dco_reg
  import cdr_hold_pkg::*;
#(
  parameter int unsigned       DCO_W    = 12,
  parameter logic [DCO_W-1:0]  DCO_INIT = {1'b1, {(DCO_W-1){1'b0}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cdr_state_e       state_i,
  input  logic             ref_present_i,
  input  logic [DCO_W-1:0] ref_word_i,
  input  logic [DCO_W-1:0] lf_word_i,
  input  logic             lf_valid_i,
  output logic [DCO_W-1:0] dco_word_o
);
  logic [DCO_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    case (state_i)
      ST_RESET: word_d = DCO_INIT;
      ST_ACQ: begin
        if (ref_present_i)   word_d = ref_word_i;
        else if (lf_valid_i) word_d = lf_word_i;
      end
      ST_TRACK: if (lf_valid_i)    word_d = lf_word_i;
      ST_HOLD:  if (ref_present_i) word_d = ref_word_i;
      default:  word_d = word_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= DCO_INIT;
    else         word_q <= word_d;
  end

  assign dco_word_o = word_q;

  p_holdover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD && !ref_present_i) |=> $stable(word_q));
  p_track_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TRACK && !lf_valid_i) |=> $stable(word_q));
  p_cal_static_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CAL) |=> $stable(word_q));
endmodule

// File: rtl/cdr_out_gate.sv
module cdr_out_gate
  import cdr_hold_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_entry_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             squelch_i,
  input  logic             clk_dis_i,
  input  logic             data_i,
  output logic [DIV_W-1:0] div_shift_o,
  output logic             data_o,
  output logic             clk_en_o
);
  logic [DIV_W-1:0] div_q;
  logic             data_q, clk_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      data_q   <= 1'b0;
      clk_en_q <= 1'b0;
    end else begin
      if (cal_entry_i) div_q <= rate_shift(rate_sel_i);
      data_q   <= data_i & ~squelch_i;
      clk_en_q <= ~clk_dis_i;
    end
  end

  assign div_shift_o = div_q;
  assign data_o      = data_q;
  assign clk_en_o    = clk_en_q;

  p_squelch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squelch_i |=> !data_o);
  p_clk_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_dis_i |=> !clk_en_o);
  p_rate_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_entry_i |=> $stable(div_shift_o));
endmodule

// File: rtl/cdr_hold_ctrl.sv
module cdr_hold_ctrl
  import cdr_hold_pkg::*;
#(
  parameter int unsigned      DCO_W     = 12,
  parameter int unsigned      MIN_PULSE = 8,
  parameter logic [DCO_W-1:0] DCO_INIT  = {1'b1, {(DCO_W-1){1'b0}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rcal_i,
  input  logic             ltr_ni,
  input  logic             ref_present_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             squelch_i,
  input  logic             clk_dis_i,
  input  logic             data_i,
  input  logic [DCO_W-1:0] lf_word_i,
  input  logic             lf_valid_i,
  input  logic [DCO_W-1:0] ref_word_i,
  input  logic             lock_i,
  input  logic             cal_done_i,
  output logic [DCO_W-1:0] dco_word_o,
  output logic [2:0]       div_shift_o,
  output logic             data_o,
  output logic             clk_en_o,
  output logic             cal_start_o,
  output logic [2:0]       state_o
);
  logic       long_hi;
  logic       cal_entry;
  cdr_state_e state;

  cdr_rst_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rcal_i    (rcal_i),
    .long_hi_o (long_hi)
  );

  cdr_hold_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .long_hi_i   (long_hi),
    .rcal_i      (rcal_i),
    .cal_done_i  (cal_done_i),
    .lock_i      (lock_i),
    .ltr_ni      (ltr_ni),
    .state_o     (state),
    .cal_entry_o (cal_entry),
    .cal_start_o (cal_start_o)
  );

  cdr_dco_reg #(.DCO_W(DCO_W), .DCO_INIT(DCO_INIT)) u_dco (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .ref_present_i (ref_present_i),
    .ref_word_i    (ref_word_i),
    .lf_word_i     (lf_word_i),
    .lf_valid_i    (lf_valid_i),
    .dco_word_o    (dco_word_o)
  );

  cdr_out_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cal_entry_i (cal_entry),
    .rate_sel_i  (rate_sel_i),
    .squelch_i   (squelch_i),
    .clk_dis_i   (clk_dis_i),
    .data_i      (data_i),
    .div_shift_o (div_shift_o),
    .data_o      (data_o),
    .clk_en_o    (clk_en_o)
  );

  assign state_o = state;

  p_reset_reinit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |=> (dco_word_o == DCO_INIT));
endmodule

// File: tb/tb_cdr_hold_ctrl.sv
module tb_cdr_hold_ctrl;
  localparam int DCO_W = 12;
  localparam logic [DCO_W-1:0] INIT = 12'h800;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rcal = 1'b0, ltr_n = 1'b1, refp = 1'b0, sq = 1'b0, cd = 1'b0, din = 1'b0;
  logic [1:0] rate = 2'b00;
  logic [DCO_W-1:0] lf_word = '0, ref_word = '0;
  logic lf_valid = 1'b0, lock = 1'b0, cal_done = 1'b0;
  logic [DCO_W-1:0] dco;
  logic [2:0] div, st;
  logic dout, clk_en, cal_start;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdr_hold_ctrl #(.DCO_W(DCO_W), .MIN_PULSE(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rcal_i(rcal), .ltr_ni(ltr_n),
    .ref_present_i(refp), .rate_sel_i(rate), .squelch_i(sq), .clk_dis_i(cd),
    .data_i(din), .lf_word_i(lf_word), .lf_valid_i(lf_valid),
    .ref_word_i(ref_word), .lock_i(lock), .cal_done_i(cal_done),
    .dco_word_o(dco), .div_shift_o(div), .data_o(dout), .clk_en_o(clk_en),
    .cal_start_o(cal_start), .state_o(st)
  );

  // {exp_data, exp_clk_en, rate, squelch, clk_dis, din, exp_div}
  localparam logic [9:0] VEC [6] = '{
    10'b1_1_00_0_0_1_000,
    10'b0_1_01_1_0_1_001,
    10'b1_0_10_0_1_1_010,
    10'b0_0_11_1_1_0_100,
    10'b0_1_00_0_0_0_000,
    10'b1_1_11_0_0_1_100
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    rcal = 1'b1;
    repeat (n) tick();
    rcal = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    chk("R1 state", st, 0);
    chk("R1 dco", dco, INIT);
    chk("R1 div", div, 0);
    chk("R1 data", dout, 0);
    chk("R1 clk_en", clk_en, 0);
    chk("R1 cal_start", cal_start, 0);
    rst_ni = 1'b1;
    tick();
    chk("R3 enter cal", st, 1);
    chk("R3 cal_start", cal_start, 1);
    tick();
    chk("R3 cal_start single", cal_start, 0);
    cal_done = 1'b1; tick(); cal_done = 1'b0;
    chk("R3 to acquire", st, 2);

    // table walk: rate latch at calibration start, output gating
    for (int i = 0; i < 6; i++) begin
      rate = VEC[i][7:6]; sq = VEC[i][5]; cd = VEC[i][4]; din = VEC[i][3];
      pulse(8);
      chk("R4 div", div, VEC[i][2:0]);
      chk("R10 data", dout, VEC[i][9]);
      chk("R11 clk_en", clk_en, VEC[i][8]);
      cal_done = 1'b1; tick(); cal_done = 1'b0;
    end
    sq = 1'b0; cd = 1'b0; din = 1'b0;

    // R4: mid-run rate change ignored
    rate = 2'b01; tick();
    chk("R4 rate ignored", div, 4);

    // R5 in ACQUIRE without reference
    lf_word = 12'h3A5; lf_valid = 1'b1; tick(); lf_valid = 1'b0;
    chk("R5 acq load", dco, 12'h3A5);
    lf_word = 12'h111; tick();
    chk("R5 no strobe", dco, 12'h3A5);

    // R2 short pulse ignored
    pulse(7);
    chk("R2 short state", st, 2);
    chk("R2 short dco", dco, 12'h3A5);

    // R2 long pulse
    rate = 2'b11;
    rcal = 1'b1;
    repeat (8) tick();
    chk("R2 long state", st, 0);
    rcal = 1'b0; tick();
    chk("R2 to cal", st, 1);
    chk("R2 dco reinit", dco, INIT);
    chk("R3 cal_start again", cal_start, 1);

    // R7 ltr ignored in CALIBRATE, R3 loop filter ignored in CALIBRATE
    ltr_n = 1'b0; lf_word = 12'h123; lf_valid = 1'b1; tick();
    chk("R7 ltr ignored in cal", st, 1);
    chk("R3 dco static in cal", dco, INIT);
    ltr_n = 1'b1; lf_valid = 1'b0;
    cal_done = 1'b1; tick(); cal_done = 1'b0;
    chk("R3 acquire", st, 2);

    // R6 lock -> TRACK
    lock = 1'b1; tick();
    chk("R6 to track", st, 3);
    lf_word = 12'h5C3; lf_valid = 1'b1; tick(); lf_valid = 1'b0;
    chk("R5 track load", dco, 12'h5C3);

    // R7 HOLD, R8 holdover
    ltr_n = 1'b0; tick();
    chk("R7 to hold", st, 4);
    lf_word = 12'h0F0; lf_valid = 1'b1; tick(); tick(); lf_valid = 1'b0;
    chk("R8 frozen", dco, 12'h5C3);

    // R9 reference in HOLD
    refp = 1'b1; ref_word = 12'h9AB; tick();
    chk("R9 hold ref", dco, 12'h9AB);
    ref_word = 12'h9AC; tick();
    chk("R9 hold ref follow", dco, 12'h9AC);
    refp = 1'b0;

    // R7 release, R6 re-lock and loss
    ltr_n = 1'b1; tick();
    chk("R7 release", st, 2);
    tick();
    chk("R6 relock", st, 3);
    lock = 1'b0; tick();
    chk("R6 lock loss", st, 2);

    // R9 reference centring in ACQUIRE
    refp = 1'b1; ref_word = 12'h246; lf_word = 12'h777; lf_valid = 1'b1; tick();
    lf_valid = 1'b0; refp = 1'b0;
    chk("R9 acq ref", dco, 12'h246);

    // R10/R11 direct toggles
    din = 1'b1; tick();
    chk("R10 pass", dout, 1);
    sq = 1'b1; tick();
    chk("R10 squelch", dout, 0);
    cd = 1'b1; tick();
    chk("R11 disabled", clk_en, 0);
    cd = 1'b0; tick();
    chk("R11 enabled", clk_en, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule